// File: doc/BRIEF.md
# Built-in Logic Block Observer Register

This block is a small register whose role is set by a two-bit mode code. It can act as an ordinary parallel register, a serial scan chain, a linear-feedback register, or a register that clears itself on the clock. In feedback mode it has two uses. With the parallel inputs held at zero, it steps through pseudo-random test patterns. With live inputs, it folds a response stream into a signature.

Test logic uses the block in a fixed order. First it scans in a nonzero seed. It then runs the feedback mode for a number of cycles. Finally it scans the result out, or reads it from the parallel outputs, and compares it with a known-good value. An all-zero state never leaves zero while the data inputs are zero, so the seed must be nonzero.

The three stages are numbered 0, 1 and 2. Stage 0 is the serial head and stage 2 is the serial tail. Bit i of each bus belongs to stage i.

Top module: `bist_observer_reg`

## Requirements
- R1: While `rst` is high at a rising edge, every stage becomes 0 after that edge, whatever the mode.
- R2: Mode `mode_b0`=1, `mode_b1`=1 is the parallel mode. Each stage i loads `par_in[i]`.
- R3: Mode `mode_b0`=0, `mode_b1`=0 is the scan mode. Stage 0 loads `scan_in` and stage i loads the old value of stage i-1.
- R4: `scan_out` always equals stage 2 (`state_out[2]`).
- R5: Mode `mode_b0`=0, `mode_b1`=1 is the clear mode. All stages become 0 on the clock edge.
- R6: Mode `mode_b0`=1, `mode_b1`=0 is the feedback mode. Stage 0 becomes old stage 1 XOR old stage 2 XOR `par_in[0]`. Stage i (i>0) becomes old stage i-1 XOR `par_in[i]`.
- R7: In feedback mode with `par_in`=0, start from stages (0,1,2) = (1,0,0). The stages then pass through 010, 101, 110, 111, 011 and 001, written as stage 0 first. The eighth state is 100 again, a period of 7.
- R8: In feedback mode with `par_in`=0, the all-zero state stays all-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_b0 | input | 1 | Mode code bit 0 |
| mode_b1 | input | 1 | Mode code bit 1 |
| par_in | input | 3 | Parallel data inputs, bit i feeds stage i |
| scan_in | input | 1 | Serial input to stage 0 |
| state_out | output | 3 | Registered stage values, bit i is stage i |
| scan_out | output | 1 | Serial output, equal to stage 2 |

## Verification
All stage bits are visible on `state_out`, so a wrong next-state value appears at the outputs one cycle after the edge that produced it. The bench compares the outputs with its model after every edge. A wrong feedback tap does more than break one step. It shortens or breaks the seven-state cycle, which then differs from the model within a few cycles. A fault on the serial path shows up on `scan_out` no more than two shifts later.

// File: rtl/bist_observer_pkg.sv
package bist_observer_pkg;
  typedef enum logic [1:0] {
    OP_PARALLEL = 2'd0,
    OP_SHIFT    = 2'd1,
    OP_FEEDBACK = 2'd2,
    OP_CLEAR    = 2'd3
  } op_mode_t;
endpackage

// File: rtl/bist_mode_decode.sv
module bist_mode_decode
  import bist_observer_pkg::*;
(
  input  logic     code_b0,
  input  logic     code_b1,
  output op_mode_t op
);
  // Code assignment is fixed by the test controller that drives it.
  always_comb begin
    unique case ({code_b1, code_b0})
      2'b11:   op = OP_PARALLEL;
      2'b00:   op = OP_SHIFT;
      2'b01:   op = OP_FEEDBACK;
      default: op = OP_CLEAR;
    endcase
  end
endmodule

// File: rtl/bist_feedback.sv
module bist_feedback #(
  parameter int          WIDTH    = 3,
  parameter logic [WIDTH-1:0] TAP_MASK = 3'b110
) (
  input  logic [WIDTH-1:0] cur,
  output logic             fb
);
  // The feedback bit is the XOR of the tapped stages.
  assign fb = ^(cur & TAP_MASK);
endmodule

// File: rtl/bist_stage.sv
module bist_stage
  import bist_observer_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  op_mode_t op,
  input  logic     par_bit,
  input  logic     shift_src,
  input  logic     loop_src,
  output logic     q
);
  logic nxt;

  always_comb begin
    unique case (op)
      OP_PARALLEL: nxt = par_bit;
      OP_SHIFT:    nxt = shift_src;
      OP_FEEDBACK: nxt = loop_src ^ par_bit;
      default:     nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= nxt;
  end
endmodule

// File: rtl/bist_observer_reg.sv
module bist_observer_reg
  import bist_observer_pkg::*;
#(
  parameter int               WIDTH    = 3,
  parameter logic [WIDTH-1:0] TAP_MASK = 3'b110
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_b0,
  input  logic             mode_b1,
  input  logic [WIDTH-1:0] par_in,
  input  logic             scan_in,
  output logic [WIDTH-1:0] state_out,
  output logic             scan_out
);
  localparam int LAST = WIDTH - 1;

  op_mode_t        op;
  logic            fb;
  logic [WIDTH-1:0] st;
  logic [WIDTH-1:0] shift_src;
  logic [WIDTH-1:0] loop_src;

  bist_mode_decode u_dec (
    .code_b0 (mode_b0),
    .code_b1 (mode_b1),
    .op      (op)
  );

  bist_feedback #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK)) u_fb (
    .cur (st),
    .fb  (fb)
  );

  // Stage 0 takes scan_in in shift mode and the feedback bit in feedback mode.
  // Every later stage takes its predecessor in both modes.
  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_stage
      if (gi == 0) begin : g_head
        assign shift_src[gi] = scan_in;
        assign loop_src[gi]  = fb;
      end else begin : g_body
        assign shift_src[gi] = st[gi-1];
        assign loop_src[gi]  = st[gi-1];
      end
      bist_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .par_bit   (par_in[gi]),
        .shift_src (shift_src[gi]),
        .loop_src  (loop_src[gi]),
        .q         (st[gi])
      );
    end
  endgenerate

  assign state_out = st;
  assign scan_out  = st[LAST];

  // R1: reset clears every stage
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (state_out == '0));

  // R2: parallel mode loads the data inputs
  a_r2_parallel_load: assert property (@(posedge clk) disable iff (rst)
    (mode_b0 && mode_b1) |=> (state_out == $past(par_in)));

  // R3: scan mode shifts toward stage LAST
  a_r3_scan_shift: assert property (@(posedge clk) disable iff (rst)
    (!mode_b0 && !mode_b1) |=>
      (state_out == {$past(state_out[LAST-1:0]), $past(scan_in)}));

  // R5: clear mode empties the register
  a_r5_sync_clear: assert property (@(posedge clk) disable iff (rst)
    (!mode_b0 && mode_b1) |=> (state_out == '0));

  // R6: feedback mode, later stages take the predecessor XOR data
  a_r6_feedback_body: assert property (@(posedge clk) disable iff (rst)
    (mode_b0 && !mode_b1) |=>
      (state_out[LAST:1] == ($past(state_out[LAST-1:0]) ^ $past(par_in[LAST:1]))));

  // R8: the zero state does not leave zero without input
  a_r8_zero_lockup: assert property (@(posedge clk) disable iff (rst)
    (mode_b0 && !mode_b1 && state_out == '0 && par_in == '0) |=> (state_out == '0));
endmodule

// File: tb/bist_observer_reg_tb_top.sv
module bist_observer_reg_tb_top;
  localparam int W = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         mode_b0 = 1'b1;
  logic         mode_b1 = 1'b1;
  logic [W-1:0] par_in = '0;
  logic         scan_in = 1'b0;
  logic [W-1:0] state_out;
  logic         scan_out;

  int n_checks = 0;
  int n_fails  = 0;
  logic [W-1:0] expect_q = '0;

  always #4 clk = ~clk;

  bist_observer_reg dut_i (
    .clk (clk), .rst (rst), .mode_b0 (mode_b0), .mode_b1 (mode_b1),
    .par_in (par_in), .scan_in (scan_in),
    .state_out (state_out), .scan_out (scan_out)
  );

  function automatic logic [W-1:0] model_next(logic r, logic b0, logic b1,
                                              logic [W-1:0] q, logic [W-1:0] d, logic si);
    logic [W-1:0] n;
    if (r) return '0;
    case ({b1, b0})
      2'b11: n = d;
      2'b00: n = {q[1:0], si};
      2'b01: n = {q[1] ^ d[2], q[0] ^ d[1], q[1] ^ q[2] ^ d[0]};
      default: n = '0;
    endcase
    return n;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Apply one cycle of inputs on the falling edge and check after the next rising edge.
  task automatic step(logic r, logic b0, logic b1, logic [W-1:0] d, logic si, string tag);
    rst = r; mode_b0 = b0; mode_b1 = b1; par_in = d; scan_in = si;
    expect_q = model_next(r, b0, b1, expect_q, d, si);
    @(posedge clk);
    @(negedge clk);
    check(tag, state_out, expect_q);
    check("R4 scan_out", {2'b00, scan_out}, {2'b00, expect_q[2]});
  endtask

  task automatic seed(logic [W-1:0] v);
    for (int k = W - 1; k >= 0; k--) step(1'b0, 1'b0, 1'b0, '0, v[k], "R3 seed shift");
  endtask

  initial begin
    #1600000;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [W-1:0] seq [7];
    seq[0] = 3'b010; seq[1] = 3'b101; seq[2] = 3'b011; seq[3] = 3'b111;
    seq[4] = 3'b110; seq[5] = 3'b100; seq[6] = 3'b001;
    void'($urandom(32'd2024));
    @(negedge clk);
    step(1'b1, 1'b1, 1'b1, 3'b111, 1'b1, "R1 reset");
    step(1'b1, 1'b0, 1'b1, 3'b101, 1'b1, "R1 reset");
    step(1'b0, 1'b1, 1'b1, 3'b110, 1'b0, "R2 parallel");
    step(1'b0, 1'b0, 1'b1, 3'b111, 1'b1, "R5 clear");
    // R8: zero state with zero data stays zero
    for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 1'b0, '0, 1'b0, "R8 lockup");
    // R7: seed stage0=1 and walk the full period
    seed(3'b001);
    check("R7 seed", state_out, 3'b001);
    for (int k = 0; k < 7; k++) begin
      step(1'b0, 1'b1, 1'b0, '0, 1'b0, "R6 feedback");
      check("R7 sequence", state_out, seq[k]);
    end
    // R3: scan a pattern through to scan_out
    seed(3'b101);
    step(1'b0, 1'b1, 1'b1, 3'b011, 1'b0, "R2 parallel");
    // R6: signature compaction with live data
    for (int k = 0; k < 20; k++)
      step(1'b0, 1'b1, 1'b0, W'($urandom), 1'b0, "R6 signature");
    // Mixed random traffic over all modes
    for (int k = 0; k < 400; k++) begin
      logic [1:0] m;
      m = 2'($urandom);
      step(($urandom % 50) == 0, m[0], m[1], W'($urandom), 1'($urandom), "R2/R3/R5/R6 random");
    end
    step(1'b1, 1'b1, 1'b0, 3'b111, 1'b1, "R1 reset in feedback");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule